// File: doc/BRIEF.md
# Flash Line Buffer and Sequential Prefetch Controller

This block sits between a bus-side read port and a slow flash array read port. It keeps four line buffers. Each buffer holds one 128-bit page tagged by address bits 23 down to 4, a valid bit and three error flags. A read that matches a valid buffer completes in the same cycle. A read that misses issues one array read, returns the array data to the requester as soon as the array answers, and stores that data in the least-recently-used buffer. Data that came back with a transfer error or an uncorrectable ECC error is returned to the requester but never stored. Data that carries only a correctable single-bit flag is stored and marked valid.

After an accepted read from a master whose enable bit is set, of an access type (instruction or data) whose enable is set, the controller can fetch the next sequential page speculatively. It does this on the first cycle in which no request is presented and no array access is outstanding. Only one array access is outstanding at a time.

The request port is a valid/ready stream. The requester raises `req_valid` and must hold `req_addr`, `req_master` and `req_instr` stable until it sees `req_ready` high at a clock edge. Back-pressure is expressed only through `req_ready`. The response fields are valid in exactly the cycle in which `req_valid` and `req_ready` are both high, and there is no separate response handshake. On the array side, `arr_req` rises with `arr_page` and both stay stable until `arr_done` is seen for one cycle.

Top module: `pagebuf_prefetch`

## Requirements
- R1: After reset all buffers are invalid, `arr_req` is low, and `req_ready` is low while no request is presented.
- R2: A request whose `req_addr[23:4]` equals the tag of a valid buffer gets `req_ready` in the same cycle. The response carries that buffer's data and stored flags.
- R3: A request that misses while no array access is outstanding raises `arr_req` on the next cycle with `arr_page = req_addr[23:4]`. The request holds `arr_page` stable until `arr_done`, and completes in the `arr_done` cycle with the array data and flags.
- R4: An array result with transfer error or multi-bit error is passed to the requester but is never stored. A later read of the same page misses again.
- R5: An array result flagged only single-bit is stored as valid. Later hits on it return `rsp_ecc_single = 1`.
- R6: Every fill goes into the least-recently-used buffer. A filled or hit buffer becomes most recently used, and the buffer ages always form a permutation of 0..3.
- R7: A prefetch is scheduled only when `pf_master_en[req_master]` is set and, for `req_instr = 1`, `pf_instr_en` is set, or, for `req_instr = 0`, `pf_data_en` is set.
- R8: A scheduled prefetch targets `req_addr[23:4] + 1`. It issues on the first cycle with `req_valid` low and nothing outstanding, so `arr_req` rises two cycles after the accepting edge when the next cycle is idle.
- R9: No prefetch is issued when its target page is already valid in a buffer, or when the source page is 20'hFFFFF.
- R10: A demand miss that starts while a prefetch is scheduled but not issued cancels that prefetch.
- R11: At most one array access is outstanding. `arr_req` only falls after `arr_done`, and a miss presented during a prefetch waits for it to finish.
- R12: `flush` high for one cycle leaves every buffer invalid on the next cycle, including over a fill that completes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all buffers |
| pf_master_en | input | 4 | Per-master prefetch enable |
| pf_instr_en | input | 1 | Prefetch allowed after instruction reads |
| pf_data_en | input | 1 | Prefetch allowed after data reads |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request accepted; response fields valid |
| req_addr | input | 24 | Byte address |
| req_master | input | 2 | Requesting master ID |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data read |
| rsp_data | output | 128 | Page data |
| rsp_xfr_err | output | 1 | Transfer error |
| rsp_ecc_multi | output | 1 | Uncorrectable ECC error |
| rsp_ecc_single | output | 1 | Corrected single-bit ECC event |
| arr_req | output | 1 | Array read request |
| arr_page | output | 20 | Array page address |
| arr_done | input | 1 | Array read complete (one cycle) |
| arr_rdata | input | 128 | Array read data |
| arr_xfr_err | input | 1 | Array transfer error |
| arr_ecc_multi | input | 1 | Array multi-bit ECC error |
| arr_ecc_single | input | 1 | Array single-bit ECC event |

## Verification
The assertions check several rules on every cycle: a zero-wait answer to any hit, a stable array request until its completion, no new valid buffer after an errored result, a valid age permutation, and an empty buffer set after a flush. Some behaviour can only be seen through the bench's scenarios. These are the choice of the evicted buffer, the exact cycle and target of a prefetch, the gating by master and access type, cancellation by a demand miss, and suppression at the top page. The random run adds checks that every returned line and flag matches the page it was asked for, and that a zero-wait answer only ever comes from a page that was earlier fetched cleanly.

// File: rtl/pbp_pkg.sv
package pbp_pkg;
  typedef struct packed {
    logic xfr;
    logic mbe;
    logic sbe;
  } pbp_flags_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DEMAND = 2'd1,
    ST_PREF   = 2'd2
  } pbp_state_t;
endpackage

// File: rtl/pbp_tagstore.sv
module pbp_tagstore
  import pbp_pkg::*;
#(
  parameter int PAGE_W = 20,
  parameter int LINE_W = 128,
  parameter int NBUF   = 4,
  localparam int IW    = $clog2(NBUF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [PAGE_W-1:0] lookup_pg,
  input  logic [PAGE_W-1:0] probe_pg,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [PAGE_W-1:0] wr_pg,
  input  logic [LINE_W-1:0] wr_data,
  input  pbp_flags_t        wr_flags,
  output logic              hit,
  output logic [IW-1:0]     hit_idx,
  output logic [LINE_W-1:0] hit_data,
  output pbp_flags_t        hit_flags,
  output logic              probe_hit,
  output logic [NBUF-1:0]   valid_vec
);
  logic [PAGE_W-1:0] tag_q  [NBUF];
  logic [LINE_W-1:0] data_q [NBUF];
  pbp_flags_t        flg_q  [NBUF];
  logic [NBUF-1:0]   vld_q;
  logic [NBUF-1:0]   lk_match;
  logic [NBUF-1:0]   pr_match;

  // one comparator pair per buffer
  for (genvar g = 0; g < NBUF; g++) begin : g_cmp
    assign lk_match[g] = vld_q[g] && (tag_q[g] == lookup_pg);
    assign pr_match[g] = vld_q[g] && (tag_q[g] == probe_pg);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (lk_match[i]) hit_idx = IW'(i);
    end
  end

  assign hit       = |lk_match;
  assign hit_data  = data_q[hit_idx];
  assign hit_flags = flg_q[hit_idx];
  assign probe_hit = |pr_match;
  assign valid_vec = vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  // payload needs no reset: it is qualified by vld_q
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_pg;
      data_q[wr_idx] <= wr_data;
      flg_q[wr_idx]  <= wr_flags;
    end
  end
endmodule

// File: rtl/pbp_lru.sv
module pbp_lru #(
  parameter int NBUF = 4,
  localparam int IW  = $clog2(NBUF)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               a_en,
  input  logic [IW-1:0]      a_idx,
  input  logic               b_en,
  input  logic [IW-1:0]      b_idx,
  output logic [IW-1:0]      victim,
  output logic [NBUF*IW-1:0] rank_vec
);
  // rank 0 = most recent, NBUF-1 = least recent
  logic [IW-1:0] rank_q [NBUF];
  logic [IW-1:0] rank_m [NBUF];
  logic [IW-1:0] rank_d [NBUF];
  logic [IW-1:0] ra;
  logic [IW-1:0] rb;

  // touch A (fill) is applied before touch B (hit) so a hit ends up newest
  always_comb begin
    rank_m = rank_q;
    ra     = rank_q[a_idx];
    if (a_en) begin
      for (int i = 0; i < NBUF; i++) begin
        if (rank_q[i] < ra) rank_m[i] = rank_q[i] + IW'(1);
      end
      rank_m[a_idx] = '0;
    end
  end

  always_comb begin
    rank_d = rank_m;
    rb     = rank_m[b_idx];
    if (b_en) begin
      for (int i = 0; i < NBUF; i++) begin
        if (rank_m[i] < rb) rank_d[i] = rank_m[i] + IW'(1);
      end
      rank_d[b_idx] = '0;
    end
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (rank_q[i] == IW'(NBUF - 1)) victim = IW'(i);
    end
  end

  for (genvar g = 0; g < NBUF; g++) begin : g_out
    assign rank_vec[g*IW +: IW] = rank_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBUF; i++) rank_q[i] <= IW'(i);
    end else begin
      rank_q <= rank_d;
    end
  end
endmodule

// File: rtl/pbp_ctrl.sv
module pbp_ctrl
  import pbp_pkg::*;
#(
  parameter int PAGE_W = 20,
  parameter int NMST   = 4,
  localparam int MW    = $clog2(NMST)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [MW-1:0]     req_master,
  input  logic              req_instr,
  input  logic              lk_hit,
  input  logic              pr_hit,
  input  logic [NMST-1:0]   pf_master_en,
  input  logic              pf_instr_en,
  input  logic              pf_data_en,
  input  logic              arr_done,
  input  logic              arr_bad,
  output logic              req_ready,
  output logic              arr_req,
  output logic [PAGE_W-1:0] arr_page,
  output logic [PAGE_W-1:0] pf_page,
  output logic              fill_en,
  output logic              dem_done
);
  pbp_state_t        st_q;
  logic [PAGE_W-1:0] cur_q;
  logic              pend_q;
  logic [PAGE_W-1:0] pend_pg_q;

  logic idle, accept, trig, miss_start, pf_go, pf_drop, type_ok;

  assign idle       = (st_q == ST_IDLE);
  assign dem_done   = (st_q == ST_DEMAND) && arr_done;
  assign req_ready  = req_valid && (lk_hit || dem_done);
  assign accept     = req_ready;
  assign type_ok    = req_instr ? pf_instr_en : pf_data_en;
  assign trig       = accept && pf_master_en[req_master] && type_ok
                      && (req_page != '1);
  assign miss_start = idle && req_valid && !lk_hit;
  assign pf_go      = idle && !req_valid && pend_q && !pr_hit;
  assign pf_drop    = idle && !req_valid && pend_q && pr_hit;
  assign fill_en    = !idle && arr_done && !arr_bad;
  assign arr_req    = !idle;
  assign arr_page   = cur_q;
  assign pf_page    = pend_pg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      pend_pg_q <= '0;
    end else if (trig) begin
      pend_q    <= 1'b1;
      pend_pg_q <= req_page + PAGE_W'(1);
    end else if (miss_start || pf_go || pf_drop) begin
      pend_q    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cur_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (miss_start) begin
            st_q  <= ST_DEMAND;
            cur_q <= req_page;
          end else if (pf_go) begin
            st_q  <= ST_PREF;
            cur_q <= pend_pg_q;
          end
        end
        ST_DEMAND, ST_PREF: begin
          if (arr_done) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pagebuf_prefetch.sv
module pagebuf_prefetch
  import pbp_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LINE_W = 128,
  parameter int NBUF   = 4,
  parameter int NMST   = 4,
  localparam int OFS_W  = $clog2(LINE_W / 8),
  localparam int PAGE_W = ADDR_W - OFS_W,
  localparam int IW     = $clog2(NBUF),
  localparam int MW     = $clog2(NMST)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [NMST-1:0]   pf_master_en,
  input  logic              pf_instr_en,
  input  logic              pf_data_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [MW-1:0]     req_master,
  input  logic              req_instr,
  output logic [LINE_W-1:0] rsp_data,
  output logic              rsp_xfr_err,
  output logic              rsp_ecc_multi,
  output logic              rsp_ecc_single,
  output logic              arr_req,
  output logic [PAGE_W-1:0] arr_page,
  input  logic              arr_done,
  input  logic [LINE_W-1:0] arr_rdata,
  input  logic              arr_xfr_err,
  input  logic              arr_ecc_multi,
  input  logic              arr_ecc_single
);
  logic [PAGE_W-1:0] req_page;
  logic              lk_hit, pr_hit, fill_en, dem_done, wr_en;
  logic [IW-1:0]     hit_idx, victim;
  logic [LINE_W-1:0] hit_data;
  pbp_flags_t        hit_flags, arr_flags;
  logic [PAGE_W-1:0] pf_page;
  logic [NBUF-1:0]   valid_vec;
  logic [NBUF*IW-1:0] rank_vec;

  assign req_page  = req_addr[ADDR_W-1:OFS_W];
  assign arr_flags = '{xfr: arr_xfr_err, mbe: arr_ecc_multi, sbe: arr_ecc_single};
  assign wr_en     = fill_en && !flush;

  pbp_ctrl #(.PAGE_W(PAGE_W), .NMST(NMST)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_page(req_page), .req_master(req_master),
    .req_instr(req_instr), .lk_hit(lk_hit), .pr_hit(pr_hit),
    .pf_master_en(pf_master_en), .pf_instr_en(pf_instr_en), .pf_data_en(pf_data_en),
    .arr_done(arr_done), .arr_bad(arr_xfr_err | arr_ecc_multi),
    .req_ready(req_ready), .arr_req(arr_req), .arr_page(arr_page),
    .pf_page(pf_page), .fill_en(fill_en), .dem_done(dem_done)
  );

  pbp_tagstore #(.PAGE_W(PAGE_W), .LINE_W(LINE_W), .NBUF(NBUF)) u_tags (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lookup_pg(req_page), .probe_pg(pf_page),
    .wr_en(wr_en), .wr_idx(victim), .wr_pg(arr_page),
    .wr_data(arr_rdata), .wr_flags(arr_flags),
    .hit(lk_hit), .hit_idx(hit_idx), .hit_data(hit_data), .hit_flags(hit_flags),
    .probe_hit(pr_hit), .valid_vec(valid_vec)
  );

  pbp_lru #(.NBUF(NBUF)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .a_en(wr_en), .a_idx(victim),
    .b_en(req_ready && lk_hit), .b_idx(hit_idx),
    .victim(victim), .rank_vec(rank_vec)
  );

  always_comb begin
    if (dem_done) begin
      rsp_data       = arr_rdata;
      rsp_xfr_err    = arr_xfr_err;
      rsp_ecc_multi  = arr_ecc_multi;
      rsp_ecc_single = arr_ecc_single;
    end else begin
      rsp_data       = hit_data;
      rsp_xfr_err    = hit_flags.xfr;
      rsp_ecc_multi  = hit_flags.mbe;
      rsp_ecc_single = hit_flags.sbe;
    end
  end
endmodule

// File: rtl/pbp_chk.sv
module pbp_chk #(
  parameter int NBUF   = 4,
  parameter int PAGE_W = 20,
  localparam int IW    = $clog2(NBUF)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               req_valid,
  input logic               req_ready,
  input logic               lk_hit,
  input logic               arr_req,
  input logic [PAGE_W-1:0]  arr_page,
  input logic               arr_done,
  input logic               arr_xfr_err,
  input logic               arr_ecc_multi,
  input logic               arr_ecc_single,
  input logic [NBUF-1:0]    valid_vec,
  input logic [NBUF*IW-1:0] rank_vec
);
  logic rank_ok;

  always_comb begin
    rank_ok = 1'b1;
    for (int k = 0; k < NBUF; k++) begin
      int n;
      n = 0;
      for (int i = 0; i < NBUF; i++) begin
        if (rank_vec[i*IW +: IW] == IW'(k)) n++;
      end
      if (n != 1) rank_ok = 1'b0;
    end
  end

  p_hit_zero_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && lk_hit |-> req_ready);

  p_arr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && !arr_done |=> arr_req && $stable(arr_page));

  p_err_no_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && arr_done && (arr_xfr_err || arr_ecc_multi)
    |=> (valid_vec & ~$past(valid_vec)) == '0);

  p_sbe_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && arr_done && arr_ecc_single && !arr_xfr_err && !arr_ecc_multi && !flush
    |=> valid_vec != '0);

  p_rank_perm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rank_ok);

  p_single_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arr_req) |-> $past(arr_done));

  p_flush_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_vec == '0);
endmodule

bind pagebuf_prefetch pbp_chk #(.NBUF(NBUF), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .req_valid(req_valid), .req_ready(req_ready), .lk_hit(lk_hit),
  .arr_req(arr_req), .arr_page(arr_page), .arr_done(arr_done),
  .arr_xfr_err(arr_xfr_err), .arr_ecc_multi(arr_ecc_multi),
  .arr_ecc_single(arr_ecc_single),
  .valid_vec(valid_vec), .rank_vec(rank_vec)
);

// File: tb/tb_pagebuf_prefetch.sv
`timescale 1ns/100ps
module tb_pagebuf_prefetch;
  localparam int LAT = 3;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         flush = 0;
  logic [3:0]   pf_master_en = '0;
  logic         pf_instr_en = 0, pf_data_en = 0;
  logic         req_valid = 0, req_ready;
  logic [23:0]  req_addr = '0;
  logic [1:0]   req_master = '0;
  logic         req_instr = 0;
  logic [127:0] rsp_data;
  logic         rsp_xfr_err, rsp_ecc_multi, rsp_ecc_single;
  logic         arr_req;
  logic [19:0]  arr_page;
  logic         arr_done = 0;
  logic [127:0] arr_rdata = '0;
  logic         arr_xfr_err = 0, arr_ecc_multi = 0, arr_ecc_single = 0;

  int nchk = 0, nfail = 0, cyc = 0, fcnt = 0, acc_cyc = 0;
  logic [19:0] flog [0:4095];
  int          fcyc [0:4095];
  bit          clean [int];

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  pagebuf_prefetch dut (.*);

  function automatic logic [127:0] fdata(logic [19:0] p);
    return {p, 12'h1A5, ~p, 12'h2B6, p ^ 20'h5A5A5, 12'h3C7, {p[9:0], p[19:10]}, 12'h4D8};
  endfunction
  // flags {xfr, multi, single}
  function automatic logic [2:0] fflags(logic [19:0] p);
    return {p[5:0] == 6'h3D, p[5:0] == 6'h2E, p[5:0] == 6'h15};
  endfunction

  // flash array model
  initial begin
    forever begin
      @(negedge clk);
      if (arr_req) begin
        logic [19:0] pg;
        pg = arr_page;
        flog[fcnt] = pg; fcyc[fcnt] = cyc; fcnt++;
        repeat (LAT - 1) @(negedge clk);
        arr_done = 1; arr_rdata = fdata(pg);
        {arr_xfr_err, arr_ecc_multi, arr_ecc_single} = fflags(pg);
        @(negedge clk);
        arr_done = 0; {arr_xfr_err, arr_ecc_multi, arr_ecc_single} = '0;
      end
    end
  end

  task automatic chk(input string r, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  // called at a negedge; returns at a negedge with the request dropped
  task automatic rd(input logic [19:0] pg, input logic [1:0] m, input logic ins,
                    output logic [127:0] d, output logic [2:0] fl, output int lat);
    bit got;
    req_valid = 1; req_addr = {pg, 4'h0} | 24'(4'h8 & m); req_master = m; req_instr = ins;
    lat = 0; got = 0;
    while (!got) begin
      #1;
      if (req_ready) begin
        got = 1; d = rsp_data; fl = {rsp_xfr_err, rsp_ecc_multi, rsp_ecc_single};
        acc_cyc = cyc;
      end
      @(negedge clk);
      if (!got) lat++;
    end
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_flush();
    while (arr_req) @(negedge clk);
    flush = 1; @(negedge clk); flush = 0;
    clean.delete();
  endtask

  // read and check data/flags against the page
  task automatic rdc(input string r, input logic [19:0] pg, input logic [1:0] m,
                     input logic ins, output int lat);
    logic [127:0] d; logic [2:0] fl;
    rd(pg, m, ins, d, fl, lat);
    chk({r, " data"}, d, fdata(pg));
    chk({r, " flags"}, 128'(fl), 128'(fflags(pg)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int lat, f0, sc;
    void'($urandom(32'd5511));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 arr_req after reset", 128'(arr_req), 128'(0));
    chk("R1 ready idle", 128'(req_ready), 128'(0));
    @(negedge clk);

    // R3 miss then R2 hit
    rdc("R3 miss", 20'h00010, 0, 0, lat);
    chk("R3 miss waits", 128'(lat > 0), 128'(1));
    chk("R3 array page", 128'(flog[fcnt-1]), 128'(20'h00010));
    rdc("R2 hit", 20'h00010, 0, 0, lat);
    chk("R2 zero wait", 128'(lat), 128'(0));

    // R4 errored pages are not kept
    rdc("R4 xfr", 20'h0003D, 0, 0, lat);
    rdc("R4 xfr again", 20'h0003D, 0, 0, lat);
    chk("R4 xfr not stored", 128'(lat > 0), 128'(1));
    rdc("R4 multi", 20'h0002E, 0, 0, lat);
    rdc("R4 multi again", 20'h0002E, 0, 0, lat);
    chk("R4 multi not stored", 128'(lat > 0), 128'(1));

    // R5 single-bit kept
    rdc("R5 single", 20'h00015, 0, 0, lat);
    rdc("R5 single hit", 20'h00015, 0, 0, lat);
    chk("R5 stored", 128'(lat), 128'(0));

    // R6 LRU eviction
    do_flush();
    for (int i = 0; i < 4; i++) rdc("R6 fill", 20'h00040 + 20'(i), 0, 0, lat);
    rdc("R6 touch", 20'h00040, 0, 0, lat);
    chk("R6 touch hit", 128'(lat), 128'(0));
    rdc("R6 new", 20'h00044, 0, 0, lat);
    rdc("R6 kept", 20'h00040, 0, 0, lat);
    chk("R6 MRU kept", 128'(lat), 128'(0));
    rdc("R6 kept2", 20'h00043, 0, 0, lat);
    chk("R6 younger kept", 128'(lat), 128'(0));
    rdc("R6 evicted", 20'h00041, 0, 0, lat);
    chk("R6 LRU evicted", 128'(lat > 0), 128'(1));

    // prefetch scenarios
    do_flush();
    pf_master_en = 4'b0010; pf_instr_en = 1; pf_data_en = 0;
    rdc("R7 data read", 20'h00050, 1, 0, lat);
    f0 = fcnt; idle(6);
    chk("R7 data type blocked", 128'(fcnt - f0), 128'(0));
    rdc("R8 instr read", 20'h00060, 1, 1, lat);
    sc = acc_cyc; f0 = fcnt; idle(6);
    chk("R8 one prefetch", 128'(fcnt - f0), 128'(1));
    chk("R8 prefetch page", 128'(flog[fcnt-1]), 128'(20'h00061));
    chk("R8 prefetch cycle", 128'(fcyc[fcnt-1]), 128'(sc + 2));
    rdc("R8 prefetched hit", 20'h00061, 1, 1, lat);
    chk("R8 prefetched zero wait", 128'(lat), 128'(0));
    rdc("R7 master off", 20'h00070, 2, 1, lat);
    f0 = fcnt; idle(6);
    chk("R7 master blocked", 128'(fcnt - f0), 128'(0));
    rdc("R9 resident", 20'h00060, 1, 1, lat);
    f0 = fcnt; idle(6);
    chk("R9 resident skipped", 128'(fcnt - f0), 128'(0));
    rdc("R9 top page", 20'hFFFFF, 1, 1, lat);
    f0 = fcnt; idle(6);
    chk("R9 top suppressed", 128'(fcnt - f0), 128'(0));

    // R10: hit schedules 0x71, back-to-back miss cancels it
    f0 = fcnt;
    rdc("R10 hit", 20'h00070, 1, 1, lat);
    rdc("R10 miss", 20'h00080, 0, 0, lat);
    idle(8);
    chk("R10 only demand fetched", 128'(fcnt - f0), 128'(1));
    chk("R10 demand page", 128'(flog[fcnt-1]), 128'(20'h00080));

    // R11: miss while a prefetch is outstanding waits for it
    rdc("R11 trigger", 20'h00090, 1, 1, lat);
    idle(2);
    chk("R11 prefetch outstanding", 128'(arr_req), 128'(1));
    rdc("R11 stalled miss", 20'h000A0, 0, 0, lat);
    chk("R11 waited past prefetch", 128'(lat > LAT + 1), 128'(1));
    rdc("R11 prefetch landed", 20'h00091, 0, 0, lat);
    chk("R11 prefetch hit", 128'(lat), 128'(0));

    // R12 flush
    do_flush();
    rdc("R12 after flush", 20'h00091, 0, 0, lat);
    chk("R12 miss after flush", 128'(lat > 0), 128'(1));

    // random phase
    idle(8);
    do_flush();
    for (int n = 0; n < 400; n++) begin
      logic [19:0] pg;
      int sf;
      if (n % 50 == 0) begin
        pf_master_en = 4'($urandom); pf_instr_en = 1'($urandom); pf_data_en = 1'($urandom);
      end
      if ($urandom % 40 == 0) do_flush();
      pg = 20'h00100 + 20'($urandom % 64);
      sf = fcnt;
      rdc("R2 R3 random", pg, 2'($urandom), 1'($urandom), lat);
      if (lat == 0) chk("R2 hit only on clean page", 128'(clean.exists(int'(pg))), 128'(1));
      if (fflags(pg)[2] || fflags(pg)[1]) chk("R4 errored never hits", 128'(lat > 0), 128'(1));
      idle($urandom % 3);
      // register completed clean fetches (those no longer outstanding)
      for (int k = 0; k < fcnt; k++) begin
        if (!(k == fcnt - 1 && arr_req) && fflags(flog[k])[2:1] == 2'b00 && k >= sf - 8)
          clean[int'(flog[k])] = 1;
      end
    end

    idle(10);
    summary();
    $finish;
  end
endmodule